// File: doc/BRIEF.md
# Half-Bridge Gate Command Interlock with Deadtime

This block sits between a PWM source and the two gate drivers of one inverter leg. It takes an active-low turn-on command for the upper switch and another for the lower switch. It returns two active-high gate enables. Each command passes through a glitch filter measured in clock cycles. The two enables are mutually exclusive. Any turn-on waits until both enables have been low for a programmable deadtime. A turn-off takes effect without waiting.

A global shutdown line clears both enables in the same cycle and keeps them clear while it is held. It collects enable, overcurrent and undervoltage conditions. A per-leg supply-good input guards the upper switch. When that supply drops, the upper side disarms, and it arms again only on a new filtered turn-on edge. The lower side needs no re-arming: it follows the level of its filtered command. Three copies of this block make a three-phase driver.

Top module: `leg_gate_ctrl`

## Requirements
- R1: While `rst_n` is low, and after its release, both enables are low. An upper command held on through reset does not turn the upper enable on. A filtered off-to-on transition is needed first.
- R2: A command input at 0 requests its switch on. A command input at 1 requests it off.
- R3: A command change is accepted only after FILT_CYC consecutive clock samples of the new value. A change that lasts FILT_CYC-1 samples or fewer leaves the enable unchanged.
- R4: When an accepted command goes to off, its enable drops at the next clock edge, with no deadtime wait.
- R5: If both filtered commands request on together, both enables are held low. When one request is withdrawn, the other side resumes. The two enables are never high in the same cycle.
- R6: An enable rises only after both enables have been low for DEAD_CYC consecutive cycles.
- R7: While `shutdown` is high, both enables are low in that same cycle, and they stay low for as long as it is held.
- R8: When `shutdown` falls with the lower command on and the deadtime already elapsed, the lower enable rises at the first clock edge.
- R9: When `hs_supply_ok` is low, the upper enable drops at the next edge and the upper side disarms. After the supply returns, a held-on upper command keeps the enable low until the command goes off and then on again.
- R10: Shutdown does not disarm the upper side. With the upper command held on, the upper enable returns at the first edge after `shutdown` falls, once the deadtime has elapsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hi_cmd_n | input | 1 | Upper switch command, 0 requests on |
| lo_cmd_n | input | 1 | Lower switch command, 0 requests on |
| shutdown | input | 1 | Global forced off, active high |
| hs_supply_ok | input | 1 | Upper-side supply good, active high |
| hi_gate | output | 1 | Upper gate enable |
| lo_gate | output | 1 | Lower gate enable |

## Verification
Two events can land on the same clock edge. In the first, one side's filtered turn-off and the other side's filtered turn-on are accepted together. The bench provokes this by swapping both commands in one cycle, then checks the exact edges: the old enable drops one cycle after acceptance, and the new one rises only DEAD_CYC cycles later. In the second, the release of shutdown coincides with a deadtime that has already expired. The bench judges this at the single edge after release, for the lower side (level-driven) and for the armed upper side. A cycle-level reference model is also compared on every clock during a long random phase of command, shutdown and supply changes.

// File: rtl/leg_gate_ctrl.sv
module leg_gate_ctrl #(
  parameter int FILT_CYC = 30,
  parameter int DEAD_CYC = 31
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hi_cmd_n,
  input  logic lo_cmd_n,
  input  logic shutdown,
  input  logic hs_supply_ok,
  output logic hi_gate,
  output logic lo_gate
);

  localparam int FW = $clog2(FILT_CYC + 1);
  localparam int DW = $clog2(DEAD_CYC + 1);
  localparam logic [FW-1:0] FLIM = FW'(FILT_CYC - 1);
  localparam logic [DW-1:0] DLIM = DW'(DEAD_CYC - 1);

  // index 1 = upper, index 0 = lower
  logic [1:0]    smp, filt;
  logic [FW-1:0] run [2];
  logic          hi_seen, hs_arm, hi_q, lo_q;
  logic [DW-1:0] dead_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp    <= 2'b10;
      filt   <= 2'b10;
      run[0] <= '0;
      run[1] <= '0;
    end else begin
      smp <= {~hi_cmd_n, ~lo_cmd_n};
      for (int i = 0; i < 2; i++) begin
        if (smp[i] == filt[i]) begin
          run[i] <= '0;
        end else if (run[i] == FLIM) begin
          filt[i] <= smp[i];
          run[i]  <= '0;
        end else begin
          run[i] <= run[i] + 1'b1;
        end
      end
    end
  end

  wire hi_rise = filt[1] & ~hi_seen;
  wire dead_ok = (dead_cnt == DLIM);
  wire hi_nxt  = ~shutdown & hs_supply_ok & (hs_arm | hi_rise) & filt[1] & ~filt[0]
               & (hi_q | (~lo_q & dead_ok));
  wire lo_nxt  = ~shutdown & filt[0] & ~filt[1] & (lo_q | (~hi_q & dead_ok));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_seen  <= 1'b1;
      hs_arm   <= 1'b0;
      hi_q     <= 1'b0;
      lo_q     <= 1'b0;
      dead_cnt <= '0;
    end else begin
      hi_seen <= filt[1];
      if (!hs_supply_ok)  hs_arm <= 1'b0;
      else if (hi_rise)   hs_arm <= 1'b1;
      hi_q <= hi_nxt;
      lo_q <= lo_nxt;
      if (hi_q | lo_q)            dead_cnt <= '0;
      else if (dead_cnt != DLIM)  dead_cnt <= dead_cnt + 1'b1;
    end
  end

  assign hi_gate = hi_q & ~shutdown;
  assign lo_gate = lo_q & ~shutdown;

  p_never_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_gate && lo_gate));
  p_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (filt[0] && filt[1]) |=> (!hi_q && !lo_q));
  p_off_fast_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !filt[1] |=> !hi_q);
  p_gap_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lo_q) |-> (!$past(hi_q) && !$past(hi_q, 2)));
  p_gap_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_q) |-> (!$past(lo_q) && !$past(lo_q, 2)));
  p_shut_now_r7: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> (!hi_gate && !lo_gate));
  p_supply_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_supply_ok |=> !hi_q);

endmodule

// File: tb/leg_gate_ctrl_bench.sv
`timescale 1ns/100ps
module leg_gate_ctrl_bench;
  localparam int FILT = 6;
  localparam int DEAD = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hi_cmd_n = 1'b0;
  logic lo_cmd_n = 1'b1;
  logic shutdown = 1'b0;
  logic hs_supply_ok = 1'b1;
  logic hi_gate, lo_gate;

  int checks = 0;
  int errors = 0;
  bit checking = 0;
  bit done = 0;
  string cur_tag = "R1";

  always #2.5 clk = ~clk;

  leg_gate_ctrl #(.FILT_CYC(FILT), .DEAD_CYC(DEAD)) u_leg_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .hi_cmd_n(hi_cmd_n), .lo_cmd_n(lo_cmd_n),
    .shutdown(shutdown), .hs_supply_ok(hs_supply_ok),
    .hi_gate(hi_gate), .lo_gate(lo_gate));

  // behavioural reference: sampled level, accepted level, run lengths
  bit m_sh, m_sl, m_fh, m_fl, m_seen, m_arm, m_hi, m_lo;
  int m_rh, m_rl, m_dead;

  always @(posedge clk) begin : mdl
    bit nfh, nfl, narm, nhi, nlo, rise, dok;
    int nrh, nrl, nd;
    if (!rst_n) begin
      m_sh = 1; m_fh = 1; m_sl = 0; m_fl = 0; m_rh = 0; m_rl = 0;
      m_seen = 1; m_arm = 0; m_hi = 0; m_lo = 0; m_dead = 0;
    end else begin
      nfh = m_fh; nrh = m_rh; nfl = m_fl; nrl = m_rl;
      if (m_sh == m_fh) nrh = 0;
      else if (m_rh + 1 >= FILT) begin nfh = m_sh; nrh = 0; end
      else nrh = m_rh + 1;
      if (m_sl == m_fl) nrl = 0;
      else if (m_rl + 1 >= FILT) begin nfl = m_sl; nrl = 0; end
      else nrl = m_rl + 1;
      rise = m_fh && !m_seen;
      dok  = (m_dead >= DEAD - 1);
      narm = !hs_supply_ok ? 1'b0 : (rise ? 1'b1 : m_arm);
      nhi  = !shutdown && hs_supply_ok && (m_arm || rise) && m_fh && !m_fl
             && (m_hi || (!m_lo && dok));
      nlo  = !shutdown && m_fl && !m_fh && (m_lo || (!m_hi && dok));
      nd   = (m_hi || m_lo) ? 0 : ((m_dead < DEAD - 1) ? m_dead + 1 : m_dead);
      m_seen = m_fh;
      m_sh = !hi_cmd_n; m_sl = !lo_cmd_n;
      m_fh = nfh; m_rh = nrh; m_fl = nfl; m_rl = nrl;
      m_arm = narm; m_hi = nhi; m_lo = nlo; m_dead = nd;
    end
  end

  always @(negedge clk) begin
    if (checking) begin
      checks++;
      if (hi_gate !== (m_hi && !shutdown) || lo_gate !== (m_lo && !shutdown)) begin
        errors++;
        $display("FAIL %s model: actual hi=%b lo=%b expected hi=%b lo=%b at %0t",
                 cur_tag, hi_gate, lo_gate, m_hi && !shutdown, m_lo && !shutdown, $time);
      end
    end
  end

  task automatic sync_in();
    @(negedge clk); #1;
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit eh, input bit el, input string tag);
    checks++;
    if (hi_gate !== eh || lo_gate !== el) begin
      errors++;
      $display("FAIL %s: actual hi=%b lo=%b expected hi=%b lo=%b at %0t",
               tag, hi_gate, lo_gate, eh, el, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 20000);
    errors++;
    $display("FAIL R1 watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    // R1: reset with upper command held on
    wt(3);
    checking = 1;
    chk(0, 0, "R1 in reset");
    wt(5);
    sync_in(); rst_n = 1;
    wt(40); chk(0, 0, "R1 held command after reset");

    // R2 / R9: fresh edge arms upper side
    cur_tag = "R2";
    sync_in(); hi_cmd_n = 1;
    wt(20); chk(0, 0, "R2 command off");
    sync_in(); hi_cmd_n = 0;
    wt(20); chk(1, 0, "R2 command on after fresh edge");

    // R4 / R6: swap both commands in one cycle
    cur_tag = "R6";
    sync_in(); hi_cmd_n = 1; lo_cmd_n = 0;
    wt(7); chk(1, 0, "R3 not yet accepted");
    wt(1); chk(0, 0, "R4 upper off without deadtime");
    wt(7); chk(0, 0, "R6 lower still in deadtime");
    wt(1); chk(0, 1, "R6 lower on after deadtime");

    // R5: both requested
    cur_tag = "R5";
    sync_in(); hi_cmd_n = 0;
    wt(20); chk(0, 0, "R5 both requested refused");
    sync_in(); lo_cmd_n = 1;
    wt(30); chk(1, 0, "R5 upper resumes after lower withdrawn");

    // R3: short pulses suppressed, full-length pulse accepted
    cur_tag = "R3";
    sync_in(); hi_cmd_n = 1;
    wt(4);
    sync_in(); hi_cmd_n = 0;
    wt(20); chk(1, 0, "R3 short upper off-pulse ignored");
    sync_in(); lo_cmd_n = 0;
    wt(4);
    sync_in(); lo_cmd_n = 1;
    wt(20); chk(1, 0, "R3 short lower on-pulse ignored");
    sync_in(); hi_cmd_n = 1;
    wt(5);
    sync_in(); hi_cmd_n = 0;
    wt(2); chk(0, 0, "R3 full-length pulse accepted");
    wt(30); chk(1, 0, "R3 upper back on");

    // R7 / R8: shutdown and release into lower level
    cur_tag = "R7";
    sync_in(); shutdown = 1;
    #0.5 chk(0, 0, "R7 shutdown same cycle");
    wt(10); chk(0, 0, "R7 shutdown held");
    sync_in(); hi_cmd_n = 1; lo_cmd_n = 0;
    wt(20); chk(0, 0, "R7 commands during shutdown");
    cur_tag = "R8";
    sync_in(); shutdown = 0;
    wt(1); chk(0, 1, "R8 lower follows level at release");

    // R9: supply loss disarms upper side
    cur_tag = "R9";
    sync_in(); lo_cmd_n = 1; hi_cmd_n = 0;
    wt(40); chk(1, 0, "R9 upper on before supply loss");
    sync_in(); hs_supply_ok = 0;
    wt(1); chk(0, 0, "R9 upper off on supply loss");
    wt(10);
    sync_in(); hs_supply_ok = 1;
    wt(40); chk(0, 0, "R9 held level does not re-arm");
    sync_in(); hi_cmd_n = 1;
    wt(20);
    sync_in(); hi_cmd_n = 0;
    wt(30); chk(1, 0, "R9 fresh edge re-arms");

    // R10: shutdown keeps arming
    cur_tag = "R10";
    sync_in(); shutdown = 1;
    wt(12);
    sync_in(); shutdown = 0;
    wt(1); chk(1, 0, "R10 upper resumes at release");

    // random phase against the model
    cur_tag = "R6";
    for (int k = 0; k < 300; k++) begin
      sync_in();
      hi_cmd_n     = $urandom_range(1, 0);
      lo_cmd_n     = $urandom_range(1, 0);
      shutdown     = ($urandom_range(15, 0) == 0);
      hs_supply_ok = ($urandom_range(15, 0) != 0);
      wt($urandom_range(12, 1));
    end
    wt(2);
    finish_run();
  end
endmodule